// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned N-bit operands over several clock cycles. It uses one N-bit adder and one 2N-bit accumulation register. When a start pulse is accepted, the multiplier operand goes into the low half of the accumulation register, the high half is cleared, and the multiplicand is captured in its own N-bit register.

The block then runs N steps, one per clock cycle. In each step it looks at the lowest bit of the accumulation register. If that bit is set, the multiplicand is added into the high half. In the same cycle the whole register, including the adder's carry-out, moves one place to the right. The multiplier bits are used up from the bottom as the product grows from the top, so no separate multiplier register is needed.

After the last step a one-cycle done pulse appears and the full 2N-bit product can be read. The product stays on the output until the next accepted start. A start that arrives while a multiplication is running has no effect.

Top module: `shift_add_mult`

## Requirements
- R1: While reset is high, and on the first cycle after it, `product_o` is all zeros and `done_o` is low.
- R2: When `start_i` is sampled high while idle, `product_o` equals {N zero bits, `mplier_i`} on the next cycle.
- R3: When `done_o` is high, `product_o` equals the unsigned 2N-bit product of the `mcand_i` and `mplier_i` values sampled with the accepted start.
- R4: `done_o` goes high in the cycle that follows the N-th rising clock edge after the edge that accepted the start. It is never high at any other time.
- R5: `done_o` is high for exactly one cycle per accepted start.
- R6: While a multiplication is in progress, `start_i` and any operand changes are ignored. The result and its timing stay those of the operation already running.
- R7: While idle with `start_i` low, `product_o` holds its value whatever the operand inputs do.
- R8: All-ones times all-ones gives (2^N-1)^2. The carry from every step is kept, so no high-order bit is lost.
- R9: A zero operand on either side gives a zero product, and the block still takes the full N steps.
- R10: A start presented in the same cycle as `done_o` is accepted, and it begins a new operation at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begins a multiplication when idle |
| mcand_i | input | N | Multiplicand operand |
| mplier_i | input | N | Multiplier operand |
| product_o | output | 2N | Accumulation register, full product once done |
| done_o | output | 1 | One-cycle pulse marking a valid product |

## Verification
Suppose the step counter is wrong by even one count. Then `done_o` appears a cycle early or late, and a product that is missing or has an extra shift is seen on that same cycle. A dropped adder carry or a wrong bit in the shift path corrupts the high half. This shows up in the done cycle for the operands with large values, all-ones in particular. A bad load path shows on `product_o` in the very first cycle after start, before any step has run.

// File: rtl/shift_add_mult_pkg.sv
package shift_add_mult_pkg;

    localparam int DEF_WIDTH = 32;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } mul_state_e;

    typedef struct packed {
        logic load;
        logic step;
    } mul_cmd_t;

    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic logic fa_sum(input logic a, input logic b, input logic c);
        return a ^ b ^ c;
    endfunction

    function automatic logic fa_carry(input logic a, input logic b, input logic c);
        return (a & b) | (c & (a ^ b));
    endfunction

endpackage

// File: rtl/shift_add_mult_adder.sv
module shift_add_mult_adder #(
    parameter int N = shift_add_mult_pkg::DEF_WIDTH
) (
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    output logic [N-1:0] sum_o,
    output logic         cout_o
);
    import shift_add_mult_pkg::*;

    logic [N:0] carry;
    assign carry[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_bit
        assign sum_o[i]   = fa_sum(a_i[i], b_i[i], carry[i]);
        assign carry[i+1] = fa_carry(a_i[i], b_i[i], carry[i]);
    end

    assign cout_o = carry[N];
endmodule

// File: rtl/shift_add_mult_ctrl.sv
module shift_add_mult_ctrl #(
    parameter int N = shift_add_mult_pkg::DEF_WIDTH
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic run_o,
    output logic done_o
);
    import shift_add_mult_pkg::*;

    localparam int CW = cnt_width(N);
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    mul_state_e    state_q;
    logic [CW-1:0] step_q;
    logic          done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_RUN;
                        step_q  <= '0;
                    end
                end
                ST_RUN: begin
                    if (step_q == LAST) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        step_q <= step_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign run_o  = (state_q == ST_RUN);
    assign done_o = done_q;
endmodule

// File: rtl/shift_add_mult_dpath.sv
module shift_add_mult_dpath #(
    parameter int N = shift_add_mult_pkg::DEF_WIDTH
) (
    input  logic                          clk,
    input  logic                          rst,
    input  shift_add_mult_pkg::mul_cmd_t  cmd_i,
    input  logic [N-1:0]                  mcand_i,
    input  logic [N-1:0]                  mplier_i,
    output logic [2*N-1:0]                acc_o
);
    localparam int W = 2 * N;

    logic [N-1:0] mcand_q;
    logic [W-1:0] acc_q;
    logic [N-1:0] addend;
    logic [N-1:0] sum;
    logic         cout;
    logic [W-1:0] acc_next;

    assign addend = acc_q[0] ? mcand_q : '0;

    shift_add_mult_adder #(.N(N)) adder_i (
        .a_i    (acc_q[W-1:N]),
        .b_i    (addend),
        .sum_o  (sum),
        .cout_o (cout)
    );

    // carry re-enters at the top as the register moves right
    assign acc_next = {cout, sum, acc_q[N-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            mcand_q <= '0;
            acc_q   <= '0;
        end else if (cmd_i.load) begin
            mcand_q <= mcand_i;
            acc_q   <= {{N{1'b0}}, mplier_i};
        end else if (cmd_i.step) begin
            acc_q   <= acc_next;
        end
    end

    assign acc_o = acc_q;
endmodule

// File: rtl/shift_add_mult.sv
module shift_add_mult #(
    parameter int N = shift_add_mult_pkg::DEF_WIDTH
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start_i,
    input  logic [N-1:0]   mcand_i,
    input  logic [N-1:0]   mplier_i,
    output logic [2*N-1:0] product_o,
    output logic           done_o
);
    import shift_add_mult_pkg::*;

    logic     run_q;
    mul_cmd_t cmd;

    assign cmd.load = start_i & ~run_q;
    assign cmd.step = run_q;

    shift_add_mult_ctrl #(.N(N)) ctrl_i (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .run_o   (run_q),
        .done_o  (done_o)
    );

    shift_add_mult_dpath #(.N(N)) dpath_i (
        .clk      (clk),
        .rst      (rst),
        .cmd_i    (cmd),
        .mcand_i  (mcand_i),
        .mplier_i (mplier_i),
        .acc_o    (product_o)
    );
endmodule

// File: rtl/shift_add_mult_chk.sv
module shift_add_mult_chk #(
    parameter int N = shift_add_mult_pkg::DEF_WIDTH
) (
    input logic           clk,
    input logic           rst,
    input logic           start_i,
    input logic [N-1:0]   mcand_i,
    input logic [N-1:0]   mplier_i,
    input logic [2*N-1:0] product_o,
    input logic           done_o,
    input logic           run_q
);
    logic           trk_q;
    int             cyc_q;
    logic [2*N-1:0] exp_q;
    logic           accept;

    assign accept = start_i && !run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            trk_q <= 1'b0;
            cyc_q <= 0;
            exp_q <= '0;
        end else if (accept) begin
            trk_q <= 1'b1;
            cyc_q <= 0;
            exp_q <= {{N{1'b0}}, mcand_i} * {{N{1'b0}}, mplier_i};
        end else if (done_o) begin
            trk_q <= 1'b0;
        end else if (trk_q) begin
            cyc_q <= cyc_q + 1;
        end
    end

    // R1
    rst_state_chk: assert property (@(posedge clk)
        rst |=> (product_o == '0 && !done_o));

    // R2
    load_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> product_o == {{N{1'b0}}, $past(mplier_i)});

    // R3
    result_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> product_o == exp_q);

    // R4
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (trk_q && cyc_q == N));

    // R4
    done_due_chk: assert property (@(posedge clk) disable iff (rst)
        (trk_q && cyc_q == N) |-> done_o);

    // R5
    pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run_q && !start_i) |=> $stable(product_o));
endmodule

bind shift_add_mult shift_add_mult_chk #(.N(N)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .mcand_i   (mcand_i),
    .mplier_i  (mplier_i),
    .product_o (product_o),
    .done_o    (done_o),
    .run_q     (run_q)
);

// File: tb/shift_add_mult_tb_top.sv
module shift_add_mult_tb_top;
    localparam int N = 32;
    localparam int W = 2 * N;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic [N-1:0] mcand_i = '0;
    logic [N-1:0] mplier_i = '0;
    logic [W-1:0] product_o;
    logic         done_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    shift_add_mult #(.N(N)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .mcand_i   (mcand_i),
        .mplier_i  (mplier_i),
        .product_o (product_o),
        .done_o    (done_o)
    );

    task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] ref_mul(input logic [N-1:0] a, input logic [N-1:0] b);
        return {{N{1'b0}}, a} * {{N{1'b0}}, b};
    endfunction

    // inj: step index at which a stray start is driven (-1 for none)
    task automatic do_mul(input logic [N-1:0] a, input logic [N-1:0] b,
                          input string tag, input int inj);
        int n;
        logic [W-1:0] exp;
        exp = ref_mul(a, b);
        @(negedge clk);
        start_i = 1'b1; mcand_i = a; mplier_i = b;
        @(negedge clk);
        start_i = 1'b0;
        check(product_o == {{N{1'b0}}, b}, {"R2 load ", tag}, product_o, {{N{1'b0}}, b});
        check(done_o == 1'b0, {"R4 early done ", tag}, W'(done_o), '0);
        n = 0;
        while (!done_o && n < N + 4) begin
            if (n == inj) begin
                start_i = 1'b1; mcand_i = ~a; mplier_i = ~b;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        start_i = 1'b0;
        check(n == N, {"R4 latency ", tag}, W'(n), W'(N));
        check(product_o == exp, {"R3 product ", tag}, product_o, exp);
        @(negedge clk);
        check(done_o == 1'b0, {"R5 pulse ", tag}, W'(done_o), '0);
        check(product_o == exp, {"R7 hold ", tag}, product_o, exp);
    endtask

    task automatic t_reset();
        check(product_o == '0, "R1 product", product_o, '0);
        check(done_o == 1'b0, "R1 done", W'(done_o), '0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(product_o == '0 && done_o == 1'b0, "R1 after release", product_o, '0);
    endtask

    task automatic t_directed();
        do_mul(N'(2), N'(3), "R3 small", -1);
        do_mul('1, '1, "R8 max*max", -1);
        do_mul('1, N'(1), "R8 max*1", -1);
        do_mul(N'(32'h8000_0000), N'(32'h8000_0000), "R8 msb*msb", -1);
        do_mul('0, N'(32'h1234_5678), "R9 zero mcand", -1);
        do_mul(N'(32'hdead_beef), '0, "R9 zero mplier", -1);
    endtask

    task automatic t_random();
        for (int i = 0; i < 24; i++) begin
            do_mul(N'($urandom), N'($urandom), "R3 random", -1);
        end
    endtask

    task automatic t_ignore();
        do_mul(N'(32'h0001_2345), N'(32'h00ab_cdef), "R6 stray start", 3);
        do_mul(N'(32'hffff_0000), N'(32'h0000_ffff), "R6 stray late", N - 2);
    endtask

    task automatic t_hold();
        logic [W-1:0] keep;
        do_mul(N'(7), N'(9), "R7 base", -1);
        keep = product_o;
        for (int i = 0; i < 6; i++) begin
            mcand_i = N'($urandom); mplier_i = N'($urandom);
            @(negedge clk);
            check(product_o == keep && !done_o, "R7 idle hold", product_o, keep);
        end
    endtask

    task automatic t_back2back();
        int n;
        logic [N-1:0] b2;
        b2 = N'(32'h0000_0101);
        @(negedge clk);
        start_i = 1'b1; mcand_i = N'(11); mplier_i = N'(13);
        @(negedge clk);
        start_i = 1'b0;
        n = 0;
        while (!done_o && n < N + 4) begin
            @(negedge clk);
            n++;
        end
        check(product_o == W'(143), "R10 first product", product_o, W'(143));
        start_i = 1'b1; mcand_i = N'(32'h0000_0300); mplier_i = b2;
        @(negedge clk);
        start_i = 1'b0;
        check(product_o == {{N{1'b0}}, b2}, "R10 restart load", product_o, {{N{1'b0}}, b2});
        n = 0;
        while (!done_o && n < N + 4) begin
            @(negedge clk);
            n++;
        end
        check(n == N, "R10 restart latency", W'(n), W'(N));
        check(product_o == ref_mul(N'(32'h0000_0300), b2), "R10 restart product",
              product_o, ref_mul(N'(32'h0000_0300), b2));
    endtask

    initial begin
        t_reset();
        t_directed();
        t_random();
        t_ignore();
        t_hold();
        t_back2back();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule